// File: doc/BRIEF.md
# Power Domain Sequencer

This block turns a handful of on-chip power domains on and off in hardware. Each domain is governed by three controls: a power switch, an isolation clamp and a reset line. A request pulse on a domain's up or down input starts a fixed three-step sequence. A down sequence clamps the outputs first, then holds the domain in reset, then cuts power. An up sequence runs the same steps in reverse order. A programmable settle delay separates the steps.

The three control registers are ordinary read/write registers on a simple memory-mapped port, so software can also drive them directly. The reset register is 32 bits wide. The domains use some of its bits, and every other bit is a free software reset line with its own output pin. While a domain is sequencing, the register bits it owns are locked against software writes. Which domains have an isolation bit or a reset bit, the reset-bit position of each domain, and which domains start powered down are all set by parameters.

Top module: `pdom_seq`

## Requirements
- R1: After reset, the power register equals PWR_INIT (bit d = 1 means domain d is down). A domain that starts down has its clamp engaged and its reset held. All other reset register bits read 1. The delay register holds DLY_INIT and the status register shows each domain's powered-up flag as the inverse of PWR_INIT.
- R2: The register map is byte-addressed on an 8-bit address:
  - 0x10: power register, bit d = domain d, 1 = down.
  - 0x58: isolation register, bit d, 0 = clamped.
  - 0x30: 32-bit reset register, 0 = held in reset.
  - 0x04: delay register, 8 bits. Writing 0 stores 1, and bits above 7 are dropped.
  - 0x08: status register, read only. Bit d = busy, bit 8+d = domain d last completed in the powered-up state.
  
  A write with bus_sel and bus_wr high takes effect at the clock edge. Reads are combinational.
- R3: A down request on an idle domain engages the clamp one edge after acceptance. The domain enters reset D+1 edges later, and power is removed D+1 edges after that, where D is the delay register value.
- R4: An up request runs the reverse order with the same spacing: power on, then reset release, then clamp release.
- R5: A step whose control the domain does not have (no isolation bit or no reset bit) changes nothing. It takes one edge instead of D+1.
- R6: A request to a domain that is busy is ignored, and the running sequence continues unchanged.
- R7: While a domain is busy, software writes to its power bit, its isolation bit and its reset bit are ignored.
- R8: If up and down are requested in the same cycle for an idle domain, the up sequence runs.
- R9: Reset register bits not owned by a busy domain follow software writes on sw_rst_n. A write of 0 followed by a write of 1 produces a reset pulse.
- R10: The busy bit is set from the edge that accepts a request until the edge that applies (or skips) the final step. At that same edge the powered-up flag takes the sequence direction.
- R11: dom_pwr_en is the inverse of the power bit. dom_iso_n follows the isolation bit, or is 1 for a domain without one. dom_rst_n follows the domain's reset register bit, or is 1 for a domain without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| dom_up_req | input | NDOM | Per-domain power-up request pulse |
| dom_down_req | input | NDOM | Per-domain power-down request pulse |
| dom_pwr_en | output | NDOM | Power switch enable, 1 = powered |
| dom_iso_n | output | NDOM | Isolation clamp, 0 = clamped |
| dom_rst_n | output | NDOM | Domain reset, 0 = held |
| sw_rst_n | output | 32 | All software reset lines, 0 = held |

## Verification
The bench builds three domains with mixed parameters:
- Domain 0 has both an isolation bit and a reset bit.
- Domain 1 lacks a reset bit.
- Domain 2 lacks an isolation bit and starts powered down.

This lets both skipped-step cases and a non-trivial reset state be observed. The delay register is run at 2 and at 5, so the D+1 spacing is seen at two settings. In the middle of a down sequence, the bench issues the opposite request and writes to each of the busy domain's three owned bits. The outputs are compared every cycle against the expected sequence.

// File: rtl/pdom_seq.sv
module pdom_seq #(
  parameter int NDOM = 2,
  parameter int DLY_W = 8,
  parameter logic [DLY_W-1:0] DLY_INIT = 4,
  parameter logic [NDOM-1:0] PWR_INIT = '0,
  parameter logic [NDOM-1:0] HAS_ISO = '1,
  parameter logic [NDOM-1:0] HAS_RST = '1,
  parameter logic [NDOM*5-1:0] RST_IDX = {5'd18, 5'd16}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NDOM-1:0] dom_up_req,
  input  logic [NDOM-1:0] dom_down_req,
  output logic [NDOM-1:0] dom_pwr_en,
  output logic [NDOM-1:0] dom_iso_n,
  output logic [NDOM-1:0] dom_rst_n,
  output logic [31:0]     sw_rst_n
);

  localparam logic [7:0] A_DLY  = 8'h04;
  localparam logic [7:0] A_STAT = 8'h08;
  localparam logic [7:0] A_PWR  = 8'h10;
  localparam logic [7:0] A_RST  = 8'h30;
  localparam logic [7:0] A_ISO  = 8'h58;

  function automatic logic [31:0] rst_start();
    logic [31:0] v;
    v = '1;
    for (int d = 0; d < NDOM; d++)
      if (HAS_RST[d] && PWR_INIT[d]) v[RST_IDX[d*5 +: 5]] = 1'b0;
    return v;
  endfunction

  localparam logic [31:0]     RST_RV = rst_start();
  localparam logic [NDOM-1:0] ISO_RV = ~(HAS_ISO & PWR_INIT);

  logic [NDOM-1:0] pwr_q, iso_q, pwr_d, iso_d;
  logic [31:0]     rst_q, rst_d, own_rst;
  logic [DLY_W-1:0] dly_q;
  logic [NDOM-1:0] busy_q, on_q;
  logic [NDOM-1:0] pwr_set, pwr_clr, iso_set, iso_clr, rst_set, rst_clr;
  logic            wr_en;

  assign wr_en = bus_sel & bus_wr;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic busy, up, on, act;
    logic [1:0] step;
    logic [DLY_W-1:0] wcnt;
    logic fire;

    assign fire = busy && (wcnt == '0);
    assign pwr_clr[d] = fire && up && step == 2'd0;
    assign pwr_set[d] = fire && !up && step == 2'd2;
    assign iso_clr[d] = fire && !up && step == 2'd0 && HAS_ISO[d];
    assign iso_set[d] = fire && up && step == 2'd2 && HAS_ISO[d];
    assign rst_clr[d] = fire && !up && step == 2'd1 && HAS_RST[d];
    assign rst_set[d] = fire && up && step == 2'd1 && HAS_RST[d];
    assign act = pwr_clr[d] | pwr_set[d] | iso_clr[d] | iso_set[d] | rst_clr[d] | rst_set[d];
    assign busy_q[d] = busy;
    assign on_q[d] = on;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy <= 1'b0;
        up   <= 1'b0;
        on   <= ~PWR_INIT[d];
        step <= 2'd0;
        wcnt <= '0;
      end else if (!busy) begin
        if (dom_up_req[d] || dom_down_req[d]) begin
          busy <= 1'b1;
          up   <= dom_up_req[d];
          step <= 2'd0;
          wcnt <= '0;
        end
      end else if (wcnt != '0) begin
        wcnt <= wcnt - 1'b1;
      end else if (step == 2'd2) begin
        busy <= 1'b0;
        on   <= up;
      end else begin
        step <= step + 2'd1;
        wcnt <= act ? dly_q : '0;
      end
    end

    assign dom_pwr_en[d] = ~pwr_q[d];
    assign dom_iso_n[d]  = HAS_ISO[d] ? iso_q[d] : 1'b1;
    assign dom_rst_n[d]  = HAS_RST[d] ? rst_q[RST_IDX[d*5 +: 5]] : 1'b1;

    // R4
    iso_release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dom_iso_n[d]) && $past(busy)) |-> (dom_pwr_en[d] && dom_rst_n[d]));
    // R3
    pwr_off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dom_pwr_en[d]) && $past(busy)) |->
        ((!HAS_ISO[d] || !dom_iso_n[d]) && (!HAS_RST[d] || !dom_rst_n[d])));
    // R6
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(up));
    // R10
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (on == dom_pwr_en[d]));
    // R5
    wait_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wcnt != '0) |-> busy);
  end

  always_comb begin
    own_rst = '0;
    for (int d = 0; d < NDOM; d++)
      if (busy_q[d] && HAS_RST[d]) own_rst[RST_IDX[d*5 +: 5]] = 1'b1;
    pwr_d = pwr_q;
    iso_d = iso_q;
    rst_d = rst_q;
    if (wr_en && bus_addr == A_PWR) pwr_d = (bus_wdata[NDOM-1:0] & ~busy_q) | (pwr_q & busy_q);
    if (wr_en && bus_addr == A_ISO) iso_d = (bus_wdata[NDOM-1:0] & ~busy_q) | (iso_q & busy_q);
    if (wr_en && bus_addr == A_RST) rst_d = (bus_wdata & ~own_rst) | (rst_q & own_rst);
    for (int d = 0; d < NDOM; d++) begin
      if (pwr_set[d]) pwr_d[d] = 1'b1;
      if (pwr_clr[d]) pwr_d[d] = 1'b0;
      if (iso_set[d]) iso_d[d] = 1'b1;
      if (iso_clr[d]) iso_d[d] = 1'b0;
      if (rst_set[d]) rst_d[RST_IDX[d*5 +: 5]] = 1'b1;
      if (rst_clr[d]) rst_d[RST_IDX[d*5 +: 5]] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= PWR_INIT;
      iso_q <= ISO_RV;
      rst_q <= RST_RV;
      dly_q <= DLY_INIT;
    end else begin
      pwr_q <= pwr_d;
      iso_q <= iso_d;
      rst_q <= rst_d;
      if (wr_en && bus_addr == A_DLY)
        dly_q <= (bus_wdata[DLY_W-1:0] == '0) ? DLY_W'(1) : bus_wdata[DLY_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PWR:  bus_rdata[NDOM-1:0] = pwr_q;
      A_ISO:  bus_rdata[NDOM-1:0] = iso_q;
      A_RST:  bus_rdata = rst_q;
      A_DLY:  bus_rdata[DLY_W-1:0] = dly_q;
      A_STAT: begin
        bus_rdata[NDOM-1:0] = busy_q;
        bus_rdata[8 +: NDOM] = on_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign sw_rst_n = rst_q;

endmodule

// File: tb/pdom_seq_tb.sv
module pdom_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0] dom_up_req = '0, dom_down_req = '0;
  logic [2:0] dom_pwr_en, dom_iso_n, dom_rst_n;
  logic [31:0] sw_rst_n;

  int checks = 0;
  int failures = 0;
  int cur_dly = 2;

  always #5 clk = ~clk;

  pdom_seq #(
    .NDOM(3), .DLY_W(8), .DLY_INIT(8'd2),
    .PWR_INIT(3'b100), .HAS_ISO(3'b011), .HAS_RST(3'b101),
    .RST_IDX({5'd20, 5'd18, 5'd16})
  ) u_dut (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .dom_up_req, .dom_down_req, .dom_pwr_en, .dom_iso_n, .dom_rst_n, .sw_rst_n
  );

  // addr, wdata, expected readback, expected pwr_en, iso_n, rst_n
  localparam int NV = 10;
  localparam logic [80:0] VEC [NV] = '{
    {8'h04, 32'h00000007, 32'h00000007, 3'b011, 3'b111, 3'b011},
    {8'h04, 32'h00000000, 32'h00000001, 3'b011, 3'b111, 3'b011},
    {8'h04, 32'h000001FF, 32'h000000FF, 3'b011, 3'b111, 3'b011},
    {8'h04, 32'h00000002, 32'h00000002, 3'b011, 3'b111, 3'b011},
    {8'h10, 32'h00000005, 32'h00000005, 3'b010, 3'b111, 3'b011},
    {8'h10, 32'h000000FC, 32'h00000004, 3'b011, 3'b111, 3'b011},
    {8'h58, 32'h00000006, 32'h00000006, 3'b011, 3'b110, 3'b011},
    {8'h58, 32'h00000007, 32'h00000007, 3'b011, 3'b111, 3'b011},
    {8'h30, 32'h12345678, 32'h12345678, 3'b011, 3'b111, 3'b110},
    {8'h30, 32'hFFEFFFFF, 32'hFFEFFFFF, 3'b011, 3'b111, 3'b011}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic run_seq(input int dom, input bit up, input bit hi, input bit hr,
                         input bit poke, input bit both, input string req);
    int s0, s1, s2;
    logic [31:0] v;
    s0 = 1;
    s1 = s0 + ((up || hi) ? cur_dly + 1 : 1);
    s2 = s1 + (hr ? cur_dly + 1 : 1);
    @(negedge clk);
    dom_up_req[dom] = up;
    dom_down_req[dom] = !up || both;
    for (int k = 0; k <= s2 + 1; k++) begin
      @(negedge clk);
      dom_up_req = '0; dom_down_req = '0;
      bus_sel = 1'b0; bus_wr = 1'b0;
      rd(8'h08, v);
      chk({req, " busy"}, 32'(v[dom]), 32'(k < s2));
      chk({req, " pwr_en"}, 32'(dom_pwr_en[dom]), 32'(up ? (k >= s0) : (k < s2)));
      chk({req, " iso_n"}, 32'(dom_iso_n[dom]), 32'(!hi ? 1'b1 : (up ? (k >= s2) : (k < s0))));
      chk({req, " rst_n"}, 32'(dom_rst_n[dom]), 32'(!hr ? 1'b1 : (up ? (k >= s1) : (k < s1))));
      if (k == s2 + 1) chk({req, " R10 done flag"}, 32'(v[8 + dom]), 32'(up));
      if (poke && k == 2) begin
        // R6 opposite request, R7 flip owned isolation bit
        dom_up_req[dom] = !up;
        dom_down_req[dom] = up;
        rd(8'h58, v);
        v[dom] = ~v[dom];
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h58; bus_wdata = v;
      end
      if (poke && k == 3) begin
        rd(8'h10, v);
        v[dom] = ~v[dom];
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = v;
      end
      if (poke && k == 4) begin
        rd(8'h30, v);
        v[16] = ~v[16]; // reset bit of domain 0
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = v;
      end
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h10, v); chk("R1 power reg", v, 32'h4);
    rd(8'h58, v); chk("R1 iso reg", v, 32'h7);
    rd(8'h30, v); chk("R1 reset reg", v, 32'hFFEFFFFF);
    rd(8'h04, v); chk("R1 delay reg", v, 32'h2);
    rd(8'h08, v); chk("R1 status reg", v, 32'h300);
    chk("R1 pwr_en", 32'(dom_pwr_en), 32'h3);
    chk("R1 rst_n", 32'(dom_rst_n), 32'h3);
    chk("R1 iso_n", 32'(dom_iso_n), 32'h7);

    // R2 / R11 register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][80:73], VEC[i][72:41]);
      rd(VEC[i][80:73], v);
      chk("R2 readback", v, VEC[i][40:9]);
      chk("R11 pwr_en", 32'(dom_pwr_en), 32'(VEC[i][8:6]));
      chk("R11 iso_n", 32'(dom_iso_n), 32'(VEC[i][5:3]));
      chk("R11 rst_n", 32'(dom_rst_n), 32'(VEC[i][2:0]));
    end

    run_seq(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R3 R6 R7 down dom0");
    chk("R7 other domain power", 32'(dom_pwr_en[1]), 32'h1);
    run_seq(0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 up dom0");
    run_seq(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 down dom1 no reset bit");
    wr(8'h04, 32'h5);
    cur_dly = 5;
    run_seq(2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 R4 up dom2 no iso bit");
    run_seq(1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8 both requests dom1");

    // R9 software reset pulse on a free bit
    @(negedge clk);
    rd(8'h30, v);
    wr(8'h30, v & ~32'h8);
    chk("R9 pulse low", 32'(sw_rst_n[3]), 32'h0);
    chk("R9 domains unaffected", 32'(dom_rst_n), 32'h7);
    wr(8'h30, v | 32'h8);
    chk("R9 pulse high", 32'(sw_rst_n[3]), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule